// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block is a slave device that answers a host over three serial wires plus a data line that it drives only when it has something to say. Behind the wires sits 4096 bits of register storage. The host clocks in frames that each begin with a start bit of 1. A frame reads a word, writes or erases one word, fills or clears the whole array, or locks and unlocks programming. All serial inputs are sampled by one system clock. The serial clock is treated as data, and a frame bit is taken on each rising edge of it that the block sees.

A width-select input chooses the shape of the array. High gives 256 words of 16 bits with 8 address bits. Low gives 512 bytes with 9 address bits. Every programming job replaces the old contents of its target outright, with no separate erase step. Each job starts when chip select falls after a complete frame. It then keeps the block busy for a parameterised number of clock cycles. While chip select is high between frames, the host can poll the data line for the ready or busy state.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset, `sdout_oe` is 0, programming is locked, and every location reads as all ones.
- R2: Whenever `csel` is low, `sdout_oe` is 0.
- R3: A read frame is a start bit 1, then opcode bits 1,0, then the address MSB first. After the rising `sclk` edge that carries the last address bit, the block drives a 0. Each later rising edge shows the next bit of the word, MSB first. After the last bit of the word, the block drives 0.
- R4: With `wide_mode` high, the address is 8 bits wide and selects a 16-bit word. With it low, the address is 9 bits wide and selects a byte. Address bit 0 equal to 1 picks the upper byte of 16-bit word addr[8:1], and 0 picks the lower byte.
- R5: The opcode 0,0 with the two top address bits 1,1 unlocks programming, and with 0,0 locks it. A programming frame sent while locked changes no location and starts no busy period.
- R6: A word-write frame uses opcode 0,1 and is followed by a word of data, MSB first (8 bits in byte mode). When `csel` falls after the last data bit, a job starts that makes the target hold exactly the new data.
- R7: The opcode 1,1 followed by an address sets that location to all ones.
- R8: The opcode 0,0 with top address bits 1,0 sets every location to all ones.
- R9: The opcode 0,0 with top address bits 0,1, followed by a data word, writes that value to every location. In byte mode the value goes to every byte.
- R10: A job keeps the block busy for WRITE_CYCLES clock cycles, starting at the clock edge where `csel` is seen low. The new contents become visible when the busy period ends. Start bits that arrive while busy are ignored.
- R11: After a job has started, `csel` may be high with no new start bit yet accepted. From the first clock edge after `csel` rises, `sdout_oe` is 1 and `sdout` shows 0 while busy and 1 when ready. The next accepted start bit clears this status display.
- R12: If `csel` falls before the last address or data bit of a programming frame, no job starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial input |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 256 x 16 words; 0: 512 x 8 bytes (tie high when unused) |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out (read bits or ready status) |
| sdout_oe | output | 1 | Output enable for `sdout`; 0 means high impedance |

## Verification
A rising edge on `sclk` takes effect at the first `clk` edge that sees it, so any read bit it causes is due right after that edge. A falling `csel` starts a job at the next `clk` edge. Busy then ends, and the array changes, exactly WRITE_CYCLES edges later. Status appears by the first edge after `csel` rises, and the output enable drops in the same cycle that `csel` does. The bench drives inputs on falling clock edges and samples a quarter period after each rising edge. It compares both outputs on every cycle against a behavioural model that advances on the same edges. Directed read-backs confirm the stored values after each kind of job.

// File: rtl/snvm_pkg.sv
// Package: shared encodings for the three-wire serial memory slave.
// Assumes: opcode and sub-command values match the frame format in the brief.
package snvm_pkg;

    typedef enum logic [1:0] {
        OPC_EXT   = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_ERASE = 2'b11
    } snvm_opc_e;

    typedef enum logic [1:0] {
        EXT_LOCK    = 2'b00,
        EXT_FILLALL = 2'b01,
        EXT_WIPEALL = 2'b10,
        EXT_UNLOCK  = 2'b11
    } snvm_ext_e;

    typedef enum logic [1:0] {
        JOB_WORD_WR,
        JOB_WORD_ER,
        JOB_ALL_WR,
        JOB_ALL_ER
    } snvm_job_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_DONE
    } snvm_phase_e;

endpackage

// File: rtl/snvm_frame.sv
// Module: serial frame decoder.
// Does: samples the select and serial clock, shifts in the start bit, opcode,
// address and data, holds the programming lock, and raises a one-cycle launch
// when a complete programming frame ends with a falling select.
// Assumes: wide_mode is stable across a frame and the job that follows it.
module snvm_frame
    import snvm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WAW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              csel,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [WAW:0]      addr,
    output logic [DATA_W-1:0] wdata,
    output snvm_job_e         job,
    output logic              launch,
    output logic              wen,
    output snvm_phase_e       phase,
    output logic              rd_bit,
    output logic              stat_en,
    output logic              csel_q
);
    localparam int NAW  = WAW + 1;
    localparam int HALF = DATA_W / 2;
    localparam int CW   = $clog2(((DATA_W > NAW) ? DATA_W : NAW) + 1);

    logic              sclk_q;
    logic [CW-1:0]     cnt;
    snvm_opc_e         opc;
    logic [NAW-1:0]    addr_sr;
    logic [DATA_W-1:0] data_sr;
    logic [DATA_W-1:0] rd_sr;
    logic              pend;
    logic              rise;
    logic              fall;
    logic [CW-1:0]     aw_last;
    logic [CW-1:0]     dw_last;
    logic [NAW-1:0]    addr_nx;
    snvm_ext_e         ext;

    // Edge detection and per-mode frame lengths.
    always_comb begin
        rise    = csel & sclk & ~sclk_q;
        fall    = csel_q & ~csel;
        aw_last = wide_mode ? CW'(WAW - 1) : CW'(NAW - 1);
        dw_last = wide_mode ? CW'(DATA_W - 1) : CW'(HALF - 1);
        addr_nx = {addr_sr[NAW-2:0], sdin};
        ext     = wide_mode ? snvm_ext_e'(addr_nx[WAW-1 -: 2])
                            : snvm_ext_e'(addr_nx[NAW-1 -: 2]);
        launch  = fall & pend & wen & ~busy;
    end

    // Frame state machine: one step per accepted serial clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            csel_q  <= 1'b0;
            phase   <= PH_IDLE;
            cnt     <= '0;
            opc     <= OPC_EXT;
            addr_sr <= '0;
            data_sr <= '0;
            rd_sr   <= '0;
            pend    <= 1'b0;
            job     <= JOB_WORD_WR;
            wen     <= 1'b0;
            stat_en <= 1'b0;
        end else begin
            sclk_q <= sclk;
            csel_q <= csel;
            if (launch) begin
                stat_en <= 1'b1;
            end
            if (!csel) begin
                phase <= PH_IDLE;
                pend  <= 1'b0;
            end else if (rise) begin
                case (phase)
                    PH_IDLE: begin
                        if (sdin && !busy) begin
                            phase   <= PH_OPCODE;
                            cnt     <= '0;
                            addr_sr <= '0;
                            data_sr <= '0;
                            rd_sr   <= '0;
                            stat_en <= 1'b0;
                        end
                    end
                    PH_OPCODE: begin
                        opc <= snvm_opc_e'({opc[0], sdin});
                        if (cnt == CW'(1)) begin
                            phase <= PH_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_sr <= addr_nx;
                        cnt     <= cnt + 1'b1;
                        if (cnt == aw_last) begin
                            cnt <= '0;
                            case (opc)
                                OPC_READ:  phase <= PH_READ;
                                OPC_WRITE: begin
                                    phase <= PH_DATA;
                                    job   <= JOB_WORD_WR;
                                end
                                OPC_ERASE: begin
                                    phase <= PH_DONE;
                                    job   <= JOB_WORD_ER;
                                    pend  <= 1'b1;
                                end
                                default: begin
                                    case (ext)
                                        EXT_UNLOCK: begin
                                            wen   <= 1'b1;
                                            phase <= PH_DONE;
                                        end
                                        EXT_LOCK: begin
                                            wen   <= 1'b0;
                                            phase <= PH_DONE;
                                        end
                                        EXT_WIPEALL: begin
                                            job   <= JOB_ALL_ER;
                                            pend  <= 1'b1;
                                            phase <= PH_DONE;
                                        end
                                        default: begin
                                            job   <= JOB_ALL_WR;
                                            phase <= PH_DATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    PH_DATA: begin
                        data_sr <= {data_sr[DATA_W-2:0], sdin};
                        cnt     <= cnt + 1'b1;
                        if (cnt == dw_last) begin
                            phase <= PH_DONE;
                            pend  <= 1'b1;
                        end
                    end
                    PH_READ: begin
                        if (cnt == '0) begin
                            rd_sr <= rd_word;
                            cnt   <= CW'(1);
                        end else begin
                            rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign addr   = addr_sr;
    assign wdata  = data_sr;
    assign rd_bit = rd_sr[DATA_W-1];

endmodule

// File: rtl/snvm_prog_timer.sv
// Module: programming job timer.
// Does: latches a launched job, stays busy for WRITE_CYCLES clocks and pulses
// commit in the last busy cycle so the array applies the job.
// Assumes: WRITE_CYCLES >= 1; launch only arrives while not busy.
module snvm_prog_timer
    import snvm_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int NAW          = 9,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  snvm_job_e         job_in,
    input  logic [NAW-1:0]    addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              commit,
    output snvm_job_e         job_q,
    output logic [NAW-1:0]    addr_q,
    output logic [DATA_W-1:0] data_q
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Countdown of the busy window and capture of the job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            job_q  <= JOB_WORD_WR;
            addr_q <= '0;
            data_q <= '0;
        end else if (launch) begin
            remain <= CNT_W'(WRITE_CYCLES);
            job_q  <= job_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy   = (remain != '0);
    assign commit = (remain == CNT_W'(1));

endmodule

// File: rtl/snvm_array.sv
// Module: storage array with word and byte views.
// Does: holds DEPTH words of DATA_W bits, applies committed jobs (word or
// byte write/erase, fill, wipe) and presents the addressed word or byte,
// left-aligned, for reading.
// Assumes: in byte mode address bit 0 selects the upper (1) or lower half.
module snvm_array
    import snvm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wide_mode,
    input  logic                       commit,
    input  snvm_job_e                  job,
    input  logic [$clog2(DEPTH):0]     addr,
    input  logic [DATA_W-1:0]          data,
    input  logic [$clog2(DEPTH):0]     rd_addr,
    output logic [DATA_W-1:0]          rd_word
);
    localparam int WAW  = $clog2(DEPTH);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [WAW-1:0]    w_idx;
    logic [WAW-1:0]    r_idx;
    logic [DATA_W-1:0] w_val;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] r_word;

    // Index decode and merged value for a single-location job.
    always_comb begin
        w_idx = wide_mode ? addr[WAW-1:0] : addr[WAW:1];
        r_idx = wide_mode ? rd_addr[WAW-1:0] : rd_addr[WAW:1];
        fill  = (job == JOB_WORD_ER) ? '1 : data;
        if (wide_mode) begin
            w_val = fill;
        end else if (addr[0]) begin
            w_val = {fill[HALF-1:0], mem[w_idx][HALF-1:0]};
        end else begin
            w_val = {mem[w_idx][DATA_W-1:HALF], fill[HALF-1:0]};
        end
    end

    // Array update on the committing cycle of a job.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (commit) begin
            case (job)
                JOB_ALL_ER: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= '1;
                    end
                end
                JOB_ALL_WR: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= wide_mode ? data : {2{data[HALF-1:0]}};
                    end
                end
                default: mem[w_idx] <= w_val;
            endcase
        end
    end

    // Read view: whole word, or chosen byte moved to the top half.
    always_comb begin
        r_word = mem[r_idx];
        if (wide_mode) begin
            rd_word = r_word;
        end else if (rd_addr[0]) begin
            rd_word = {r_word[DATA_W-1:HALF], {HALF{1'b0}}};
        end else begin
            rd_word = {r_word[HALF-1:0], {HALF{1'b0}}};
        end
    end

endmodule

// File: rtl/serial_nvm_slave.sv
// Module: three-wire serial nonvolatile memory slave (top).
// Does: joins the frame decoder, job timer and storage array, and drives the
// serial output with read bits or ready status under an output enable.
// Assumes: DEPTH is a power of two; DATA_W is even; WRITE_CYCLES >= 1.
module serial_nvm_slave
    import snvm_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int DEPTH        = 256,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wide_mode,
    input  logic csel,
    input  logic sclk,
    input  logic sdin,
    output logic sdout,
    output logic sdout_oe
);
    localparam int WAW = $clog2(DEPTH);
    localparam int NAW = WAW + 1;

    logic [NAW-1:0]    f_addr;
    logic [DATA_W-1:0] f_data;
    snvm_job_e         f_job;
    logic              launch;
    logic              wen;
    snvm_phase_e       phase;
    logic              rd_bit;
    logic              stat_en;
    logic              csel_q;
    logic              busy;
    logic              commit;
    snvm_job_e         t_job;
    logic [NAW-1:0]    t_addr;
    logic [DATA_W-1:0] t_data;
    logic [DATA_W-1:0] rd_word;

    snvm_frame #(.DATA_W(DATA_W), .WAW(WAW)) u_frame (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .csel(csel),
        .sclk(sclk), .sdin(sdin), .busy(busy), .rd_word(rd_word),
        .addr(f_addr), .wdata(f_data), .job(f_job), .launch(launch),
        .wen(wen), .phase(phase), .rd_bit(rd_bit), .stat_en(stat_en),
        .csel_q(csel_q)
    );

    snvm_prog_timer #(.DATA_W(DATA_W), .NAW(NAW), .WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .job_in(f_job),
        .addr_in(f_addr), .data_in(f_data), .busy(busy), .commit(commit),
        .job_q(t_job), .addr_q(t_addr), .data_q(t_data)
    );

    snvm_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .commit(commit),
        .job(t_job), .addr(t_addr), .data(t_data), .rd_addr(f_addr),
        .rd_word(rd_word)
    );

    // Output mux: read bits in a read frame, otherwise ready status.
    always_comb begin
        sdout_oe = csel & csel_q &
                   ((phase == PH_READ) | ((phase == PH_IDLE) & stat_en));
        sdout    = (phase == PH_READ) ? rd_bit : ~busy;
    end

endmodule

// File: rtl/snvm_checker.sv
// Module: property checker for the serial memory slave, bound to the top.
// Does: checks output gating, job launch conditions and the busy window.
// Assumes: connected to the top's internal job-control nets by the bind below.
module snvm_checker (
    input logic clk,
    input logic rst_n,
    input logic csel,
    input logic sdout_oe,
    input logic busy,
    input logic commit,
    input logic launch,
    input logic wen
);
    p_hiz_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !csel |-> !sdout_oe);

    p_launch_needs_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> wen);

    p_launch_on_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !csel);

    p_launch_starts_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);

    p_commit_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

endmodule

bind serial_nvm_slave snvm_checker u_snvm_checker (
    .clk(clk), .rst_n(rst_n), .csel(csel), .sdout_oe(sdout_oe),
    .busy(busy), .commit(commit), .launch(launch), .wen(wen)
);

// File: tb/test_serial_nvm_slave.sv
module test_serial_nvm_slave;
    localparam int WC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wide = 1'b1;
    logic csel = 1'b0;
    logic sclk = 1'b0;
    logic sdin = 1'b0;
    logic sdout;
    logic sdout_oe;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    serial_nvm_slave #(.DATA_W(16), .DEPTH(256), .WRITE_CYCLES(WC)) i_serial_nvm_slave (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide), .csel(csel),
        .sclk(sclk), .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_mem [256];
    bit  m_csq, m_skq, m_wen, m_stat, m_pend, m_rdld;
    int  m_phase, m_n, m_op, m_addr, m_data, m_job, m_busy;
    int  l_job, l_addr, l_data, m_rdw, m_rdpos;

    function automatic int aw();
        return wide ? 8 : 9;
    endfunction
    function automatic int dw();
        return wide ? 16 : 8;
    endfunction

    function automatic int m_read(input int a);
        if (wide) return m_mem[a & 255];
        if (a & 1) return (m_mem[a >> 1] >> 8) & 255;
        return m_mem[a >> 1] & 255;
    endfunction

    task automatic m_put(input int a, input int v);
        if (wide) m_mem[a & 255] = v & 16'hFFFF;
        else if (a & 1) m_mem[a >> 1] = ((v & 255) << 8) | (m_mem[a >> 1] & 255);
        else m_mem[a >> 1] = (m_mem[a >> 1] & 16'hFF00) | (v & 255);
    endtask

    task automatic m_commit();
        case (l_job)
            0: m_put(l_addr, l_data);
            1: m_put(l_addr, 16'hFFFF);
            2: for (int i = 0; i < 256; i++)
                   m_mem[i] = wide ? l_data : (((l_data & 255) << 8) | (l_data & 255));
            default: for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
        endcase
    endtask

    always @(posedge clk) begin
        bit rise, fall, busy_old, exp_oe, exp_d;
        string tag;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
            m_csq = 0; m_skq = 0; m_wen = 0; m_stat = 0; m_pend = 0; m_rdld = 0;
            m_phase = 0; m_n = 0; m_busy = 0; m_op = 0; m_addr = 0; m_data = 0;
        end else begin
            rise = csel && sclk && !m_skq;
            fall = m_csq && !csel;
            busy_old = (m_busy > 0);
            if (m_busy > 0) begin
                if (m_busy == 1) m_commit();
                m_busy--;
            end
            if (!csel) begin
                if (fall && m_pend && m_wen && !busy_old) begin
                    m_busy = WC; l_job = m_job; l_addr = m_addr; l_data = m_data;
                    m_stat = 1;
                end
                m_phase = 0; m_pend = 0;
            end else if (rise) begin
                case (m_phase)
                    0: if (sdin && !busy_old) begin
                           m_phase = 1; m_n = 0; m_op = 0; m_addr = 0; m_data = 0;
                           m_stat = 0;
                       end
                    1: begin
                           m_op = m_op * 2 + sdin; m_n++;
                           if (m_n == 2) begin m_phase = 2; m_n = 0; end
                       end
                    2: begin
                           m_addr = m_addr * 2 + sdin; m_n++;
                           if (m_n == aw()) begin
                               m_n = 0;
                               case (m_op)
                                   2: begin m_phase = 4; m_rdld = 0; end
                                   1: begin m_phase = 3; m_job = 0; end
                                   3: begin m_phase = 5; m_job = 1; m_pend = 1; end
                                   default: case (m_addr >> (aw() - 2))
                                       3: begin m_wen = 1; m_phase = 5; end
                                       0: begin m_wen = 0; m_phase = 5; end
                                       2: begin m_job = 3; m_pend = 1; m_phase = 5; end
                                       default: begin m_job = 2; m_phase = 3; end
                                   endcase
                               endcase
                           end
                       end
                    3: begin
                           m_data = m_data * 2 + sdin; m_n++;
                           if (m_n == dw()) begin m_phase = 5; m_pend = 1; end
                       end
                    4: if (!m_rdld) begin
                           m_rdld = 1; m_rdw = m_read(m_addr); m_rdpos = dw() - 1;
                       end else m_rdpos--;
                    default: ;
                endcase
            end
            m_csq = csel; m_skq = sclk;
        end
        exp_oe = csel && m_csq && (m_phase == 4 || (m_phase == 0 && m_stat));
        if (m_phase == 4) exp_d = (m_rdld && m_rdpos >= 0) ? bit'((m_rdw >> m_rdpos) & 1) : 1'b0;
        else exp_d = (m_busy == 0);
        tag = !csel ? "R2 per-cycle" : (m_phase == 4 ? "R3 per-cycle" : "R11 per-cycle");
        #5;
        check(sdout_oe === exp_oe, tag, int'(sdout_oe), int'(exp_oe));
        if (exp_oe) check(sdout === exp_d, tag, int'(sdout), int'(exp_d));
    end

    // ---------------- stimulus tasks ----------------
    task automatic sk_bit(input bit b);
        @(negedge clk); sdin = b; sclk = 0;
        @(negedge clk); sclk = 1;
        @(negedge clk);
    endtask

    task automatic send(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(bit'((v >> i) & 1));
    endtask

    task automatic begin_frame();
        @(negedge clk); csel = 1; sclk = 0;
    endtask

    task automatic end_frame();
        @(negedge clk); csel = 0; sclk = 0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int ext_addr(input int code);
        return code << (aw() - 2);
    endfunction

    task automatic do_read(input int a, output int w);
        begin_frame();
        send(1, 1); send(2, 2); send(a, aw());
        check(sdout_oe === 1 && sdout === 0, "R3 dummy zero", int'(sdout), 0);
        w = 0;
        for (int i = 0; i < dw(); i++) begin
            sk_bit(0);
            w = w * 2 + int'(sdout);
        end
        end_frame();
        check(sdout_oe === 0, "R2 deselected hi-z", int'(sdout_oe), 0);
    endtask

    task automatic prog(input int op, input int a, input int d, input bit with_data,
                        input bit expect_busy, input bit poke_busy);
        begin_frame();
        send(1, 1); send(op, 2); send(a, aw());
        if (with_data) send(d, dw());
        end_frame();
        begin_frame();
        @(negedge clk);
        if (expect_busy) begin
            check(sdout_oe === 1 && sdout === 0, "R11 busy status", int'(sdout), 0);
            if (poke_busy) begin
                send(1, 1); send(2, 2);
                check(sdout_oe === 1 && sdout === 0, "R10 start ignored while busy",
                      int'(sdout), 0);
            end
            repeat (WC + 2) @(negedge clk);
            check(sdout_oe === 1 && sdout === 1, "R10 ready after busy", int'(sdout), 1);
        end else begin
            check(sdout_oe === 0, "R5 R12 no job started", int'(sdout_oe), 0);
        end
        end_frame();
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(sdout_oe === 0, "R1 reset hi-z", int'(sdout_oe), 0);
        do_read(3, w);
        check(w == 16'hFFFF, "R1 erased after reset", w, 16'hFFFF);

        prog(1, 3, 16'h1234, 1, 0, 0);
        do_read(3, w);
        check(w == 16'hFFFF, "R5 locked write ignored", w, 16'hFFFF);

        prog(0, ext_addr(3), 0, 0, 0, 0);
        prog(1, 3, 16'h1234, 1, 1, 0);
        do_read(3, w);
        check(w == 16'h1234, "R6 word write", w, 16'h1234);
        prog(1, 3, 16'h00F0, 1, 1, 0);
        do_read(3, w);
        check(w == 16'h00F0, "R6 overwrite replaces", w, 16'h00F0);
        prog(3, 3, 0, 0, 1, 0);
        do_read(3, w);
        check(w == 16'hFFFF, "R7 word erase", w, 16'hFFFF);

        prog(1, 7, 16'h0F0F, 1, 1, 1);
        do_read(7, w);
        check(w == 16'h0F0F, "R10 write with poke", w, 16'h0F0F);

        begin_frame();
        send(1, 1); send(1, 2); send(7, 8); send(5'h15, 5);
        end_frame();
        begin_frame();
        @(negedge clk);
        check(sdout_oe === 0, "R12 short frame no status", int'(sdout_oe), 0);
        end_frame();
        do_read(7, w);
        check(w == 16'h0F0F, "R12 short frame no change", w, 16'h0F0F);

        @(negedge clk); wide = 0;
        prog(1, 9, 8'h5A, 1, 1, 0);
        do_read(9, w);
        check(w == 8'h5A, "R4 byte write upper", w, 8'h5A);
        do_read(8, w);
        check(w == 8'hFF, "R4 lower byte untouched", w, 8'hFF);
        @(negedge clk); wide = 1;
        do_read(4, w);
        check(w == 16'h5AFF, "R4 word view of bytes", w, 16'h5AFF);

        prog(0, ext_addr(1), 16'hBEEF, 1, 1, 0);
        do_read(0, w);
        check(w == 16'hBEEF, "R9 fill first", w, 16'hBEEF);
        do_read(255, w);
        check(w == 16'hBEEF, "R9 fill last", w, 16'hBEEF);

        prog(0, ext_addr(2), 0, 0, 1, 0);
        do_read(255, w);
        check(w == 16'hFFFF, "R8 wipe last", w, 16'hFFFF);
        do_read(7, w);
        check(w == 16'hFFFF, "R8 wipe other", w, 16'hFFFF);

        prog(0, ext_addr(0), 0, 0, 0, 0);
        prog(1, 7, 16'h1111, 1, 0, 0);
        do_read(7, w);
        check(w == 16'hFFFF, "R5 relocked write ignored", w, 16'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule